// File: doc/BRIEF.md
# Periodic Interrupt Timer with Indexed Register Access

This block is the interrupt slice of a clock-calendar peripheral. It counts strobes from a 32.768 kHz time base and raises a free-running periodic interrupt. The rate comes from a 4-bit rate code that picks a power-of-two tap on a binary divider. Time of day, alarms and the update-ended event are not counted here. Their mode bits are only stored.

Software reaches three internal registers through a port pair. When `sel_i` is 0, a write loads the index register. When `sel_i` is 1, the access goes to the register that the index selects. The control register sits at index 0x0A: bits 6:4 enable the divider and bits 3:0 hold the rate code. The mode register sits at 0x0B, with bit 6 as the interrupt enable. The flag register sits at 0x0C, with bit 7 as the summary interrupt flag and bit 6 as the periodic flag.

The interrupt output is active low. It stays low until software reads the flag register through the data port.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, `irq_n_o` is 1, the flag register (index 0x0C) reads 0x00, and mode register bit 6 reads 0.
- R2: A write with `sel_i`=0 loads the index register. While `sel_i`=0, `rdata_o` shows the index. While `sel_i`=1, `rdata_o` always shows the selected register. Only a read strobe (`rd_en_i`) with `sel_i`=1 has side effects.
- R3: Index 0x0A keeps write bits 6:0 and reads bit 7 as 0. Index 0x0B keeps and returns all 8 bits, including the binary/BCD, 24-hour and daylight-saving bits 2:0, which have no other effect.
- R4: The divider runs only while control bits 6:4 equal 3'b010. With any other value, no periodic event occurs.
- R5: With rate code c from 3 to 15, the periodic event recurs every 2^(c-1) strobes of `tick_32k_i`. Code 1 gives 128 strobes and code 2 gives 256 strobes, so code 9 gives 128 Hz.
- R6: Rate code 0 produces no periodic event.
- R7: Each periodic event sets flag bit 6. While mode bit 6 is 0, bit 7 stays 0 and `irq_n_o` stays 1.
- R8: While mode bit 6 is 1, a periodic event also sets flag bit 7 and drives `irq_n_o` to 0 in the cycle after the strobe.
- R9: A data-port read of index 0x0C returns the flags and clears both of them. `irq_n_o` returns to 1 in the next cycle.
- R10: If a periodic event lands in the same cycle as a read that clears the flags, the new flags survive.
- R11: Every write to index 0x0A restarts the divider. The first event follows exactly one full period of strobes after the write.
- R12: Writes to index 0x0C or to an unmapped index change nothing. An unmapped index reads 0x00.
- R13: Events keep repeating every period without any software action other than clearing the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k_i | input | 1 | One-cycle enable strobe at 32.768 kHz |
| sel_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (read side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the selected register |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
A divider that is off by one, or that is not cleared when software writes a new rate, shows up at the ports as the periodic flag appearing one strobe early or late. That error appears on the very first period after the rate write, so the bench counts strobes from the write to the first flag for each rate code. A stale flag or a missed clear keeps `irq_n_o` low one cycle after the flag register is read. A lost event shows up as a flag register that reads 0x00 right after a read that coincided with a strobe.

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int CNT_W   = 15,
  parameter logic [7:0] IDX_CTRL = 8'h0A,
  parameter logic [7:0] IDX_MODE = 8'h0B,
  parameter logic [7:0] IDX_FLAG = 8'h0C,
  parameter logic [2:0] DIV_RUN  = 3'b010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k_i,
  input  logic       sel_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_n_o
);

  logic [7:0]       idx_q;
  logic [6:0]       ctrl_q;
  logic [7:0]       mode_q;
  logic             pf_q, irqf_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] lim;
  logic [3:0]       rate;
  logic             run, fire, wr_ctrl, rd_flag;

  assign rate    = ctrl_q[3:0];
  assign run     = (ctrl_q[6:4] == DIV_RUN) && (rate != 4'd0);
  assign wr_ctrl = wr_en_i && sel_i && (idx_q == IDX_CTRL);
  assign rd_flag = rd_en_i && sel_i && (idx_q == IDX_FLAG);
  assign fire    = tick_32k_i && run && (div_q == lim);
  assign irq_n_o = ~irqf_q;

  always_comb begin
    if (rate == 4'd1)      lim = CNT_W'(127);
    else if (rate == 4'd2) lim = CNT_W'(255);
    else                   lim = (CNT_W'(1) << (rate - 4'd1)) - CNT_W'(1);
  end

  always_comb begin
    if (!sel_i)                 rdata_o = idx_q;
    else if (idx_q == IDX_CTRL) rdata_o = {1'b0, ctrl_q};
    else if (idx_q == IDX_MODE) rdata_o = mode_q;
    else if (idx_q == IDX_FLAG) rdata_o = {irqf_q, pf_q, 6'd0};
    else                        rdata_o = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= 8'h00;
      ctrl_q <= 7'h00;
      mode_q <= 8'h00;
    end else if (wr_en_i) begin
      if (!sel_i)                 idx_q  <= wdata_i;
      else if (idx_q == IDX_CTRL) ctrl_q <= wdata_i[6:0];
      else if (idx_q == IDX_MODE) mode_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wr_ctrl || !run) div_q <= '0;
    else if (tick_32k_i)        div_q <= fire ? '0 : div_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q   <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      if (rd_flag) begin
        pf_q   <= 1'b0;
        irqf_q <= 1'b0;
      end
      if (fire) begin
        pf_q <= 1'b1;
        if (mode_q[6]) irqf_q <= 1'b1;
      end
    end
  end

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_o) |-> $past(mode_q[6]));
  a_r6_code0_silent: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_q) |-> ($past(rate) != 4'd0));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_flag && !fire) |=> (!pf_q && irq_n_o));
  a_r10_fire_wins: assert property (@(posedge clk) disable iff (rst)
    (rd_flag && fire) |=> pf_q);
  a_r11_restart: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (div_q == '0));
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_q <= lim));

endmodule

// File: tb/rtc_periodic_irq_tb.sv
module rtc_periodic_irq_tb;
  logic clk = 0, rst = 1, tick = 0, sel = 0, wr = 0, rd = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  rtc_periodic_irq u_dut (.clk(clk), .rst(rst), .tick_32k_i(tick), .sel_i(sel),
    .wr_en_i(wr), .rd_en_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n));

  localparam int NV = 8;
  localparam logic [3:0] CODES [NV] = '{4'd3, 4'd4, 4'd5, 4'd1, 4'd2, 4'd9, 4'd7, 4'd15};

  function automatic int exp_period(input logic [3:0] c);
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (c - 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wr = 1; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    bus_wr(0, i); bus_wr(1, d);
  endtask

  task automatic peek(input logic [7:0] i, output logic [7:0] v);
    bus_wr(0, i); sel = 1; #1 v = rdata;
  endtask

  task automatic read_clear(output logic [7:0] v);
    bus_wr(0, 8'h0C);
    @(negedge clk); sel = 1; rd = 1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic strobe();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  function automatic logic pf();
    return (u_dut.rdata_o[6] && sel) ? 1'b1 : 1'b0;
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 irq_n", irq_n, 1);
    peek(8'h0C, v); chk("R1 flags", v, 8'h00);
    peek(8'h0B, v); chk("R1 mode", v & 8'h40, 0);

    bus_wr(0, 8'h0B); sel = 0; #1 chk("R2 index readback", rdata, 8'h0B);
    reg_wr(8'h0B, 8'h87); peek(8'h0B, v); chk("R3 mode bits", v, 8'h87);
    reg_wr(8'h0A, 8'hA5); peek(8'h0A, v); chk("R3 ctrl bit7 zero", v, 8'h25);
    reg_wr(8'h0B, 8'h06);

    // R5 table walk
    for (int k = 0; k < NV; k++) begin
      reg_wr(8'h0A, {4'h2, CODES[k]});
      bus_wr(0, 8'h0C); sel = 1;
      n = 0;
      while (n < 20000) begin
        strobe(); n++;
        #1 if (rdata[6]) break;
      end
      chk($sformatf("R5 code %0d period", CODES[k]), n, exp_period(CODES[k]));
      chk("R7 no irq when disabled", irq_n, 1);
      read_clear(v);
      chk("R7 flag value", v, 8'h40);
    end

    // R4 divider stopped
    reg_wr(8'h0A, 8'h03); bus_wr(0, 8'h0C); sel = 1;
    for (int k = 0; k < 20; k++) strobe();
    #1 chk("R4 divider off", rdata, 8'h00);
    // R6 code 0
    reg_wr(8'h0A, 8'h20); bus_wr(0, 8'h0C); sel = 1;
    for (int k = 0; k < 300; k++) strobe();
    #1 chk("R6 code 0", rdata, 8'h00);

    // R8 / R9 enable path
    reg_wr(8'h0B, 8'h46);
    reg_wr(8'h0A, 8'h23);
    for (int k = 0; k < 3; k++) strobe();
    chk("R8 irq high before period", irq_n, 1);
    strobe();
    chk("R8 irq low", irq_n, 0);
    read_clear(v);
    chk("R9 read value", v, 8'hC0);
    chk("R9 irq released", irq_n, 1);
    peek(8'h0C, v); chk("R9 flags cleared", v, 8'h00);

    // R13 free running
    for (int k = 0; k < 3; k++) strobe();
    #1 chk("R13 not yet", rdata, 8'h00);
    strobe();
    #1 chk("R13 repeats", rdata, 8'hC0);
    read_clear(v);

    // R11 restart on write
    reg_wr(8'h0A, 8'h23); strobe(); strobe();
    reg_wr(8'h0A, 8'h23); bus_wr(0, 8'h0C); sel = 1;
    for (int k = 0; k < 3; k++) strobe();
    #1 chk("R11 no early tick", rdata, 8'h00);
    strobe();
    #1 chk("R11 tick one period later", rdata, 8'hC0);
    read_clear(v);

    // R10 coincident read and tick
    reg_wr(8'h0A, 8'h23); bus_wr(0, 8'h0C); sel = 1;
    for (int k = 0; k < 3; k++) strobe();
    @(negedge clk); tick = 1; rd = 1; #1 v = rdata;
    @(negedge clk); tick = 0; rd = 0;
    chk("R10 read before event", v, 8'h00);
    #1 chk("R10 flags survive", rdata, 8'hC0);
    chk("R10 irq held", irq_n, 0);
    read_clear(v);

    // R12 ignored writes
    reg_wr(8'h0A, 8'h20);
    reg_wr(8'h0C, 8'hFF); peek(8'h0C, v); chk("R12 flag write ignored", v, 8'h00);
    chk("R12 irq unchanged", irq_n, 1);
    reg_wr(8'h05, 8'hFF); peek(8'h05, v); chk("R12 unmapped reads 0", v, 8'h00);
    peek(8'h0B, v); chk("R12 mode unchanged", v, 8'h46);
    peek(8'h0A, v); chk("R12 ctrl unchanged", v, 8'h20);

    // R1 reset mid-operation
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    peek(8'h0B, v); chk("R1 reset clears enable", v & 8'h40, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule